// File: doc/BRIEF.md
# Write-Allocate Policy Decision Unit

This unit decides, for each write that misses the L1 data cache, whether the line should be allocated. It holds a 64-bit write-handling control register. The register is written and read through a plain register port: a write strobe with write data, and combinational read data.

The decision comes from three sources. The first is a limit mechanism. It allocates writes whose address lies below a programmable ceiling, set in steps of 4 Mbytes. A separate enable covers the 1 Mbyte window from 15 to 16 Mbytes. An external disallow input also blocks this mechanism. The second and third sources are two hint inputs from the surrounding cache logic: one marks a write to a cacheable page, the other a write to a sector. Either hint forces an allocate whatever the limit mechanism says.

The cache controller presents one request per cycle with a valid/ready handshake. It receives one registered decision per accepted request.

Top module: `wa_policy_top`

## Requirements
- R1: After reset, the control register reads as all zeros and `dec_valid_o` is 0.
- R2: A register write stores bits 31:22 as the 10-bit limit field and bit 16 as the window enable. All other bits are ignored on write and read back as zero.
- R3: `req_ready_o` is always 1. `dec_valid_o` is 1 in exactly the cycle after a cycle with `req_valid_i` high, and 0 otherwise.
- R4: A write miss with no hints and no disallow is allocated when address bits 31:22 are strictly below the limit field and the address is outside the window (effective limit = field × 4 Mbytes).
- R5: A write miss at or above the effective limit is not allocated unless a hint is set. The highest limit, 1023, covers addresses below 0xFFC00000.
- R6: With the limit field at zero, no write miss is allocated unless a hint is set.
- R7: A write miss to 0x00F00000–0x00FFFFFF (address bits 31:20 equal to 0x00F) below the limit is allocated only when the window enable is 1 or a hint is set.
- R8: A write miss with the page hint or the sector hint set is allocated regardless of the limit, the window enable and `disallow_i`.
- R9: A write miss with `disallow_i` set and no hint is not allocated.
- R10: A request that is not a write, or that hits, is never allocated, even when a hint is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_wr_i | input | 1 | Control register write strobe |
| csr_wdata_i | input | 64 | Control register write data |
| csr_rdata_o | output | 64 | Control register read data |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted (always 1) |
| req_addr_i | input | 32 | Physical address of the request |
| req_write_i | input | 1 | Request is a write |
| req_miss_i | input | 1 | Request missed the L1 data cache |
| page_hint_i | input | 1 | Write to a cacheable page |
| sector_hint_i | input | 1 | Write to a sector |
| disallow_i | input | 1 | Address is in a range where allocation is disallowed |
| dec_valid_o | output | 1 | Decision valid, one cycle after the request |
| dec_alloc_o | output | 1 | Allocate decision |

## Verification
The assertions check on every cycle the rules that depend only on the inputs and the readable register:
- the decision timing;
- that hints force an allocate;
- that the disallow input and a zero limit block allocation when no hint is present;
- that non-write or hit requests never allocate;
- that reserved bits read as zero.

The exact limit boundaries need the bench's directed scenarios and its reference model. These are the cases just below and at a limit, the 15–16 Mbyte window with the enable on and off, and the top limit of 1023. Mixed register and request traffic under random stimulus also needs the bench.

// File: rtl/wa_pkg.sv
package wa_pkg;
  localparam int CSR_W   = 64;
  localparam int ADDR_W  = 32;
  localparam int LIM_W   = 10;
  localparam int LIM_LSB = 22;
  localparam int WIN_LSB = 20;
  localparam int EN_BIT  = 16;

  typedef struct packed {
    logic write;
    logic miss;
    logic page;
    logic sector;
    logic dis;
  } wa_req_t;
endpackage

// File: rtl/wa_csr.sv
module wa_csr #(
  parameter int CSR_W   = 64,
  parameter int LIM_W   = 10,
  parameter int LIM_LSB = 22,
  parameter int EN_BIT  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CSR_W-1:0] wdata_i,
  output logic [CSR_W-1:0] rdata_o,
  output logic [LIM_W-1:0] lim_o,
  output logic             win_en_o
);
  localparam int LIM_MSB = LIM_LSB + LIM_W - 1;

  logic [LIM_W-1:0] lim_q;
  logic             en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q <= '0;
      en_q  <= 1'b0;
    end else if (wr_i) begin
      lim_q <= wdata_i[LIM_MSB:LIM_LSB];
      en_q  <= wdata_i[EN_BIT];
    end
  end

  always_comb begin
    rdata_o                   = '0;
    rdata_o[LIM_MSB:LIM_LSB]  = lim_q;
    rdata_o[EN_BIT]           = en_q;
  end

  assign lim_o    = lim_q;
  assign win_en_o = en_q;

  // reserved write bits are dropped
  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[CSR_W-1:LIM_MSB+1], wdata_i[LIM_LSB-1:EN_BIT+1],
                          wdata_i[EN_BIT-1:0]};
endmodule

// File: rtl/wa_limit_cmp.sv
module wa_limit_cmp #(
  parameter int ADDR_W  = 32,
  parameter int LIM_W   = 10,
  parameter int LIM_LSB = 22,
  parameter int WIN_LSB = 20,
  parameter int TAG_W   = ADDR_W - WIN_LSB,
  parameter logic [TAG_W-1:0] WIN_TAG = TAG_W'(15)
) (
  input  logic [TAG_W-1:0] addr_tag_i,  // address bits [ADDR_W-1:WIN_LSB]
  input  logic [LIM_W-1:0] lim_i,
  input  logic             win_en_i,
  input  logic             dis_i,
  output logic             ok_o
);
  localparam int SHIFT = LIM_LSB - WIN_LSB;

  logic [LIM_W-1:0] addr_blk;
  logic             below, in_win;

  // 4 Mbyte block index compared directly: no multiply
  assign addr_blk = addr_tag_i[TAG_W-1:SHIFT];
  assign below    = addr_blk < lim_i;
  assign in_win   = addr_tag_i == WIN_TAG;
  assign ok_o     = below && !(in_win && !win_en_i) && !dis_i;
endmodule

// File: rtl/wa_decide.sv
module wa_decide
  import wa_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    fire_i,
  input  wa_req_t req_i,
  input  logic    lim_ok_i,
  output logic    valid_o,
  output logic    alloc_o
);
  logic alloc_d;

  // hints override the limit path and the disallow input
  assign alloc_d = req_i.write && req_i.miss && (lim_ok_i || req_i.page || req_i.sector);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      alloc_o <= 1'b0;
    end else begin
      valid_o <= fire_i;
      alloc_o <= fire_i && alloc_d;
    end
  end

  logic unused_dis;
  assign unused_dis = req_i.dis;
endmodule

// File: rtl/wa_policy_top.sv
module wa_policy_top
  import wa_pkg::*;
#(
  parameter int CSR_W_P   = CSR_W,
  parameter int ADDR_W_P  = ADDR_W,
  parameter int LIM_W_P   = LIM_W,
  parameter int LIM_LSB_P = LIM_LSB,
  parameter int WIN_LSB_P = WIN_LSB,
  parameter int EN_BIT_P  = EN_BIT
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                csr_wr_i,
  input  logic [CSR_W_P-1:0]  csr_wdata_i,
  output logic [CSR_W_P-1:0]  csr_rdata_o,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [ADDR_W_P-1:0] req_addr_i,
  input  logic                req_write_i,
  input  logic                req_miss_i,
  input  logic                page_hint_i,
  input  logic                sector_hint_i,
  input  logic                disallow_i,
  output logic                dec_valid_o,
  output logic                dec_alloc_o
);
  localparam int TAG_W = ADDR_W_P - WIN_LSB_P;

  logic [LIM_W_P-1:0] lim;
  logic               win_en, lim_ok, fire;
  wa_req_t            req;

  assign req_ready_o = 1'b1;
  assign fire        = req_valid_i && req_ready_o;
  assign req         = '{write: req_write_i, miss: req_miss_i, page: page_hint_i,
                         sector: sector_hint_i, dis: disallow_i};

  wa_csr #(.CSR_W(CSR_W_P), .LIM_W(LIM_W_P), .LIM_LSB(LIM_LSB_P), .EN_BIT(EN_BIT_P)) u_csr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (csr_wr_i),
    .wdata_i (csr_wdata_i),
    .rdata_o (csr_rdata_o),
    .lim_o   (lim),
    .win_en_o(win_en)
  );

  wa_limit_cmp #(.ADDR_W(ADDR_W_P), .LIM_W(LIM_W_P), .LIM_LSB(LIM_LSB_P),
                 .WIN_LSB(WIN_LSB_P)) u_cmp (
    .addr_tag_i(req_addr_i[ADDR_W_P-1:WIN_LSB_P]),
    .lim_i     (lim),
    .win_en_i  (win_en),
    .dis_i     (disallow_i),
    .ok_o      (lim_ok)
  );

  wa_decide u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .req_i   (req),
    .lim_ok_i(lim_ok),
    .valid_o (dec_valid_o),
    .alloc_o (dec_alloc_o)
  );

  logic unused_addr;
  assign unused_addr = ^req_addr_i[WIN_LSB_P-1:0];
endmodule

// File: rtl/wa_policy_chk.sv
module wa_policy_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [63:0] csr_rdata_o,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        req_write_i,
  input logic        req_miss_i,
  input logic        page_hint_i,
  input logic        sector_hint_i,
  input logic        disallow_i,
  input logic        dec_valid_o,
  input logic        dec_alloc_o
);
  logic wm, hint;
  assign wm   = req_valid_i && req_write_i && req_miss_i;
  assign hint = page_hint_i || sector_hint_i;

  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_rdata_o & ~64'h0000_0000_FFC1_0000) == 64'd0);
  a_r3_ready: assert property (@(posedge clk_i) disable iff (!rst_ni) req_ready_o);
  a_r3_valid_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> dec_valid_o);
  a_r3_idle_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !dec_valid_o);
  a_r3_alloc_in_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_alloc_o |-> dec_valid_o);
  a_r6_zero_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wm && !hint && csr_rdata_o[31:22] == 10'd0) |=> !dec_alloc_o);
  a_r8_hint_forces: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wm && hint) |=> dec_alloc_o);
  a_r9_disallow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wm && !hint && disallow_i) |=> !dec_alloc_o);
  a_r10_no_alloc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !(req_write_i && req_miss_i)) |=> !dec_alloc_o);
endmodule

bind wa_policy_top wa_policy_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .csr_rdata_o  (csr_rdata_o),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_write_i  (req_write_i),
  .req_miss_i   (req_miss_i),
  .page_hint_i  (page_hint_i),
  .sector_hint_i(sector_hint_i),
  .disallow_i   (disallow_i),
  .dec_valid_o  (dec_valid_o),
  .dec_alloc_o  (dec_alloc_o)
);

// File: tb/tb_wa_policy_top.sv
`timescale 1ns/1ps
module tb_wa_policy_top;
  logic        clk_i = 0, rst_ni = 0;
  logic        csr_wr_i = 0;
  logic [63:0] csr_wdata_i = '0, csr_rdata_o;
  logic        req_valid_i = 0, req_ready_o;
  logic [31:0] req_addr_i = '0;
  logic        req_write_i = 0, req_miss_i = 0, page_hint_i = 0, sector_hint_i = 0;
  logic        disallow_i = 0, dec_valid_o, dec_alloc_o;

  int n_chk = 0, n_fail = 0;
  logic [9:0] m_lim = '0;
  logic       m_en = 0;

  always #5 clk_i = ~clk_i;

  wa_policy_top dut (.*);

  function automatic logic exp_alloc(logic [31:0] a, logic w, logic m, logic p, logic s,
                                     logic d, logic [9:0] lim, logic en);
    logic lim_ok;
    lim_ok = (a[31:22] < lim) && !(a[31:20] == 12'h00F && !en) && !d;
    return w && m && (lim_ok || p || s);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic csr_write(logic [63:0] d);
    @(negedge clk_i);
    csr_wr_i = 1; csr_wdata_i = d;
    @(negedge clk_i);
    csr_wr_i = 0;
    m_lim = d[31:22]; m_en = d[16];
    check("R2", csr_rdata_o, {32'd0, d[31:22], 5'd0, d[16], 16'd0});
  endtask

  task automatic apply(string req, logic [31:0] a, logic w, logic m, logic p, logic s,
                       logic d);
    logic e;
    e = exp_alloc(a, w, m, p, s, d, m_lim, m_en);
    @(negedge clk_i);
    req_valid_i = 1; req_addr_i = a; req_write_i = w; req_miss_i = m;
    page_hint_i = p; sector_hint_i = s; disallow_i = d;
    @(negedge clk_i);
    req_valid_i = 0;
    check("R3", {63'd0, dec_valid_o}, 64'd1);
    check(req, {63'd0, dec_alloc_o}, {63'd0, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    check("R1", csr_rdata_o, 64'd0);
    check("R1", {63'd0, dec_valid_o}, 64'd0);
    rst_ni = 1;
    @(negedge clk_i);
    check("R3", {63'd0, req_ready_o}, 64'd1);

    // R6 zero limit: nothing allocates without hints
    apply("R6", 32'h0000_1000, 1, 1, 0, 0, 0);
    apply("R8", 32'h0000_1000, 1, 1, 0, 1, 0);
    // R2 reserved bits ignored
    csr_write(64'hFFFF_FFFF_0000_0000 | (64'd4 << 22) | 64'h0002_FFFF);
    // limit 16 Mbytes, window disabled
    csr_write(64'd4 << 22);
    apply("R4", 32'h00EF_FFFF, 1, 1, 0, 0, 0);
    apply("R7", 32'h00F0_0000, 1, 1, 0, 0, 0);
    apply("R7", 32'h00FF_FFFF, 1, 1, 0, 1, 0);
    apply("R5", 32'h0100_0000, 1, 1, 0, 0, 0);
    apply("R9", 32'h0000_0040, 1, 1, 0, 0, 1);
    apply("R8", 32'h0100_0000, 1, 1, 1, 0, 1);
    apply("R10", 32'h0000_0040, 0, 1, 1, 1, 0);
    apply("R10", 32'h0000_0040, 1, 0, 1, 0, 0);
    csr_write((64'd4 << 22) | (64'd1 << 16));
    apply("R7", 32'h00F0_0000, 1, 1, 0, 0, 0);
    apply("R7", 32'h00FF_FFFF, 1, 1, 0, 0, 0);
    csr_write(64'd1023 << 22);
    apply("R5", 32'hFFBF_FFFF, 1, 1, 0, 0, 0);
    apply("R5", 32'hFFC0_0000, 1, 1, 0, 0, 0);
    // idle cycle: no decision
    @(negedge clk_i);
    check("R3", {63'd0, dec_valid_o}, 64'd0);

    for (int i = 0; i < 1500; i++) begin
      logic [31:0] a;
      if ($urandom_range(0, 19) == 0)
        csr_write({$urandom(), $urandom()});
      a = ($urandom_range(0, 3) == 0) ? {12'h00F, 20'($urandom())} : $urandom();
      apply("R4", a, 1'($urandom()), 1'($urandom()), ($urandom_range(0, 3) == 0),
            ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule